// File: doc/BRIEF.md
# Time Synchronization Node Sequencer

This block sequences the message exchange of a clock synchronization node that uses the Precision Time Protocol. It runs one of two state machines. In master mode it broadcasts Sync messages and answers delay requests. In slave mode it answers each Sync with a delay request, then asks for the captured timestamps to be exported once the delay response arrives. It does not build frames or capture timestamps. It drives a message engine and a PHY setup block through level commands, and each command stays asserted until that block returns its completion event.

The node's role comes from a mode input. Reset and every change of role raise a PHY setup request first, and no message is sent until setup reports completion. A status output shows the role that is actually running. Received messages are classified by their 4-bit message type code alone. The transport of each outgoing message (UDP over IPv4 or raw layer 2) comes from a select input, captured when the send command starts.

Top module: `tsync_seq`

## Requirements
- R1: A command stays asserted with unchanged contents until its completion event: `send_req_o` with `send_type_o` and `send_l2_o` until `tx_sent_i`, `phy_init_o` until `init_done_i`, and `dump_req_o` until `dump_done_i`, unless a role change cancels it.
- R2: `phy_init_o` is high after reset. It rises on the clock edge at which `mode_master_i` differs from the running role, and at that same edge all send and dump commands drop. While `phy_init_o` is high, neither a send nor a dump is issued.
- R3: A running master that is idle sends a Sync (`send_type_o` = 4'h0) starting in the cycle after `tick_i` is high.
- R4: A button release (the transition of `button_i` from 1 to 0) triggers a master Sync like a tick does. Pressing the button (0 to 1) has no effect.
- R5: A master that receives a delay request (type 4'h1) sends a delay response (type 4'h9). The response is sent in the cycle after the request when the master is idle. Otherwise one request is remembered and answered as soon as the current send completes. A pending or arriving request wins over a Sync trigger in the same cycle.
- R6: A tick or button release that arrives while a master send is in progress, or in the same cycle as a request that gets served, is dropped and not queued.
- R7: A running slave that receives a Sync (type 4'h0) while idle sends a delay request (type 4'h1) in the next cycle. After `tx_sent_i` it waits for the response.
- R8: A slave that receives a delay response (type 4'h9) while waiting raises `dump_req_o` in the next cycle. It holds it until `dump_done_i`, then returns to idle.
- R9: Message type codes other than 4'h0, 4'h1 and 4'h9, and messages with no meaning in the current role and state (a Sync sent to a master, a delay response sent to an idle slave, a Sync sent to a slave that is sending or dumping), cause no command.
- R10: `send_l2_o` takes the value of `l2_sel_i` at the edge where a send starts and holds it for the whole send.
- R11: `mode_status_o` is 0 after reset. It changes only at the edge where a pending setup completes, and it then shows the role that was set up (1 = master).
- R12: A slave that receives a Sync while waiting for a delay response abandons the wait and sends a new delay request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_master_i | input | 1 | Requested role: 1 = master, 0 = slave |
| button_i | input | 1 | Push button level, 1 = pressed |
| tick_i | input | 1 | One-cycle pulse, once per second |
| init_done_i | input | 1 | PHY setup completion event |
| tx_sent_i | input | 1 | Message-sent completion event |
| rx_valid_i | input | 1 | A message was received this cycle |
| rx_type_i | input | 4 | Message type code of the received message |
| l2_sel_i | input | 1 | Transport choice for next send: 1 = layer 2, 0 = UDP/IPv4 |
| dump_done_i | input | 1 | Timestamp export completion event |
| phy_init_o | output | 1 | PHY setup request |
| send_req_o | output | 1 | Send request to the message engine |
| send_type_o | output | 4 | Type code of the message to send |
| send_l2_o | output | 1 | Transport of the message being sent |
| dump_req_o | output | 1 | Timestamp export request |
| mode_status_o | output | 1 | Role in effect after setup, 1 = master |

## Verification
Directed sequences cover each role: a tick, then a button press and a release, then a delay request during a busy response. These show that only releases trigger, that a busy master queues one request, and that triggers are not queued. A tick and a request arrive together to show which one wins. The slave is fed an unknown type code, a response while idle, a Sync during a dump, and a Sync during the wait. These show that unexpected traffic is filtered by role and by state. Randomized traffic with mixed type codes, completion events and trigger pulses then runs in each role and is compared cycle by cycle against a bench model of the two message exchanges. This finds ordering faults the directed cases miss. Role changes made in the middle of a send confirm the cancel-and-reinitialize path.

// File: rtl/tsync_pkg.sv
// Shared constants and state types for the time synchronization sequencer.
// Assumes the 4-bit message type codes of the protocol header.
package tsync_pkg;
    localparam int TYPE_W = 4;
    localparam logic [TYPE_W-1:0] MT_SYNC  = 4'h0;
    localparam logic [TYPE_W-1:0] MT_DREQ  = 4'h1;
    localparam logic [TYPE_W-1:0] MT_DRESP = 4'h9;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_SYNC = 2'd1,
        M_RESP = 2'd2
    } mst_state_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2,
        S_DUMP = 2'd3
    } slv_state_t;
endpackage

// File: rtl/tsync_release.sv
// Button release detector: pulses for one cycle when the button leaves its
// pressed level. Assumes button_i is already synchronous to clk.
module tsync_release #(
    parameter bit PRESS_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic release_o
);
    logic pressed_now;
    logic pressed_q;

    generate
        if (PRESS_LEVEL) begin : g_high
            assign pressed_now = level_i;
        end else begin : g_low
            assign pressed_now = ~level_i;
        end
    endgenerate

    // Remember last cycle's pressed state.
    always_ff @(posedge clk) begin
        if (!rst_n) pressed_q <= 1'b0;
        else        pressed_q <= pressed_now;
    end

    assign release_o = pressed_q & ~pressed_now;
endmodule

// File: rtl/tsync_master.sv
// Master message sequencer: sends Sync on a trigger and answers delay
// requests with delay responses. Holds one pending request while busy.
// Assumes sent_i is only meaningful while send_o is high.
module tsync_master
    import tsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              trig_i,
    input  logic              rx_dreq_i,
    input  logic              sent_i,
    output logic              send_o,
    output logic [TYPE_W-1:0] type_o
);
    mst_state_t state_q, state_d;
    logic       pend_q, pend_d;

    // Next-state selection; a request beats a sync trigger.
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        case (state_q)
            M_IDLE: begin
                pend_d = 1'b0;
                if (pend_q || rx_dreq_i) state_d = M_RESP;
                else if (trig_i)         state_d = M_SYNC;
            end
            M_SYNC, M_RESP: begin
                if (rx_dreq_i) pend_d = 1'b1;
                if (sent_i)    state_d = M_IDLE;
            end
            default: state_d = M_IDLE;
        endcase
    end

    // State register, cleared whenever the master role is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            state_q <= M_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    assign send_o = (state_q != M_IDLE);
    assign type_o = (state_q == M_RESP) ? MT_DRESP : MT_SYNC;

    assert_resp_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !send_o && rx_dreq_i) |=> (send_o && type_o == MT_DRESP));

    assert_busy_trig_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && send_o && !sent_i) |=> (send_o && $stable(type_o)));
endmodule

// File: rtl/tsync_slave.sv
// Slave message sequencer: answers Sync with a delay request, waits for the
// delay response and then requests a timestamp export.
// Assumes completion inputs are only meaningful in their own state.
module tsync_slave
    import tsync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic rx_sync_i,
    input  logic rx_dresp_i,
    input  logic sent_i,
    input  logic dump_done_i,
    output logic send_o,
    output logic dump_o
);
    slv_state_t state_q, state_d;

    // Next-state selection for the request/response exchange.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE: if (rx_sync_i) state_d = S_REQ;
            S_REQ:  if (sent_i)    state_d = S_WAIT;
            S_WAIT: begin
                if (rx_dresp_i)     state_d = S_DUMP;
                else if (rx_sync_i) state_d = S_REQ;
            end
            S_DUMP: if (dump_done_i) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register, cleared whenever the slave role is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) state_q <= S_IDLE;
        else                 state_q <= state_d;
    end

    assign send_o = (state_q == S_REQ);
    assign dump_o = (state_q == S_DUMP);

    assert_sync_answered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !send_o && !dump_o && rx_sync_i) |=> send_o);

    assert_dump_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && dump_o && !dump_done_i) |=> dump_o);

    assert_send_dump_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_o && dump_o));
endmodule

// File: rtl/tsync_seq.sv
// Top of the synchronization sequencer: tracks the requested role, runs PHY
// setup on reset and on every role change, and enables the master or slave
// sequencer once setup is done. Assumes all inputs are synchronous to clk.
module tsync_seq
    import tsync_pkg::*;
#(
    parameter bit BTN_PRESS_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_master_i,
    input  logic              button_i,
    input  logic              tick_i,
    input  logic              init_done_i,
    input  logic              tx_sent_i,
    input  logic              rx_valid_i,
    input  logic [TYPE_W-1:0] rx_type_i,
    input  logic              l2_sel_i,
    input  logic              dump_done_i,
    output logic              phy_init_o,
    output logic              send_req_o,
    output logic [TYPE_W-1:0] send_type_o,
    output logic              send_l2_o,
    output logic              dump_req_o,
    output logic              mode_status_o
);
    logic              role_q;
    logic              init_q;
    logic              run_q;
    logic              stat_q;
    logic              l2_q;
    logic              mode_same;
    logic              m_en, s_en;
    logic              btn_rel, trig;
    logic              rx_sync, rx_dreq, rx_dresp;
    logic              m_send, s_send, s_dump;
    logic [TYPE_W-1:0] m_type;

    assign mode_same = (mode_master_i == role_q);
    assign m_en      = run_q &  role_q & mode_same;
    assign s_en      = run_q & ~role_q & mode_same;

    // Role tracking, setup request and published status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            role_q <= 1'b0;
            init_q <= 1'b1;
            run_q  <= 1'b0;
            stat_q <= 1'b0;
        end else if (!mode_same) begin
            role_q <= mode_master_i;
            init_q <= 1'b1;
            run_q  <= 1'b0;
        end else if (init_q && init_done_i) begin
            init_q <= 1'b0;
            run_q  <= 1'b1;
            stat_q <= role_q;
        end
    end

    // Transport capture: follows the select while idle, frozen while sending.
    always_ff @(posedge clk) begin
        if (!rst_n)          l2_q <= 1'b0;
        else if (!send_req_o) l2_q <= l2_sel_i;
    end

    assign rx_sync  = rx_valid_i && (rx_type_i == MT_SYNC);
    assign rx_dreq  = rx_valid_i && (rx_type_i == MT_DREQ);
    assign rx_dresp = rx_valid_i && (rx_type_i == MT_DRESP);
    assign trig     = tick_i | btn_rel;

    tsync_release #(.PRESS_LEVEL(BTN_PRESS_LEVEL)) u_release (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (button_i),
        .release_o (btn_rel)
    );

    tsync_master u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (m_en),
        .trig_i    (trig),
        .rx_dreq_i (rx_dreq),
        .sent_i    (tx_sent_i),
        .send_o    (m_send),
        .type_o    (m_type)
    );

    tsync_slave u_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (s_en),
        .rx_sync_i   (rx_sync),
        .rx_dresp_i  (rx_dresp),
        .sent_i      (tx_sent_i),
        .dump_done_i (dump_done_i),
        .send_o      (s_send),
        .dump_o      (s_dump)
    );

    assign phy_init_o    = init_q;
    assign send_req_o    = m_send | s_send;
    assign send_type_o   = m_send ? m_type : (s_send ? MT_DREQ : MT_SYNC);
    assign send_l2_o     = l2_q;
    assign dump_req_o    = s_dump;
    assign mode_status_o = stat_q;

    assert_single_sender_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_send, s_send}));

    assert_quiet_in_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phy_init_o |-> (!send_req_o && !dump_req_o));

    assert_role_change_inits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_same |=> phy_init_o);

    assert_init_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_init_o && !init_done_i) |=> phy_init_o);

    assert_send_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req_o && !tx_sent_i && mode_same) |=>
            (send_req_o && $stable(send_type_o)));

    assert_l2_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req_o && !tx_sent_i && mode_same) |=> $stable(send_l2_o));

    assert_status_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(phy_init_o && init_done_i) |=> $stable(mode_status_o));
endmodule

// File: tb/tsync_seq_bench.sv
module tsync_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode, btn, tick, idone, sent, rxv, l2, ddone;
    logic [3:0] rxt;
    logic       phy_init, send, sl2, dump, mstat;
    logic [3:0] stype;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    tsync_seq u_tsync_seq (
        .clk(clk), .rst_n(rst_n), .mode_master_i(mode), .button_i(btn),
        .tick_i(tick), .init_done_i(idone), .tx_sent_i(sent),
        .rx_valid_i(rxv), .rx_type_i(rxt), .l2_sel_i(l2),
        .dump_done_i(ddone), .phy_init_o(phy_init), .send_req_o(send),
        .send_type_o(stype), .send_l2_o(sl2), .dump_req_o(dump),
        .mode_status_o(mstat)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rx(input logic [3:0] t);
        rxv = 1'b1; rxt = t; cyc(); rxv = 1'b0;
    endtask

    // Master model: returns {state[1:0], pend} next, from R3, R4, R5 and R6.
    function automatic logic [2:0] mst_next(input logic [1:0] st, input logic pd,
                                            input logic trg, input logic dq, input logic snt);
        logic [1:0] ns = st;
        logic       np = pd;
        if (st == 2'd0) begin
            np = 1'b0;
            if (pd || dq) ns = 2'd2;
            else if (trg) ns = 2'd1;
        end else begin
            if (dq)  np = 1'b1;
            if (snt) ns = 2'd0;
        end
        return {ns, np};
    endfunction

    // Slave model: 0 idle, 1 request, 2 wait, 3 dump (R7, R8, R12).
    function automatic logic [1:0] slv_next(input logic [1:0] st, input logic sy,
                                            input logic dr, input logic snt, input logic dd);
        case (st)
            2'd0: return sy ? 2'd1 : 2'd0;
            2'd1: return snt ? 2'd2 : 2'd1;
            2'd2: return dr ? 2'd3 : (sy ? 2'd1 : 2'd2);
            default: return dd ? 2'd0 : 2'd3;
        endcase
    endfunction

    function automatic logic [3:0] pick_type(input int unsigned r);
        case (r % 4)
            0: return 4'h0;
            1: return 4'h1;
            2: return 4'h9;
            default: return 4'h3;
        endcase
    endfunction

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 0; mode = 0; btn = 0; tick = 0; idone = 0; sent = 0;
        rxv = 0; rxt = 0; l2 = 0; ddone = 0;
        repeat (3) cyc();
        chk("R2 reset init", phy_init, 1);
        chk("R2 reset send", send, 0);
        chk("R8 reset dump", dump, 0);
        chk("R11 reset status", mstat, 0);
        rst_n = 1;
        cyc();
        rx(4'h0);
        chk("R2 no send during init", send, 0);
        idone = 1; cyc(); idone = 0;
        chk("R1 init drop", phy_init, 0);
        chk("R11 slave status", mstat, 0);

        // Slave directed
        l2 = 1; rx(4'h0);
        chk("R7 req sent", {send, stype}, {1'b1, 4'h1});
        chk("R10 l2 captured", sl2, 1);
        l2 = 0; cyc();
        chk("R1 send held", send, 1);
        chk("R10 l2 held", sl2, 1);
        sent = 1; cyc(); sent = 0;
        chk("R1 send ends", send, 0);
        rx(4'h0);
        chk("R12 sync restarts", {send, stype}, {1'b1, 4'h1});
        sent = 1; cyc(); sent = 0;
        rx(4'h3);
        chk("R9 unknown type", {send, dump}, 0);
        rx(4'h9);
        chk("R8 dump raised", dump, 1);
        cyc();
        chk("R1 dump held", dump, 1);
        rx(4'h0);
        chk("R9 sync during dump", {send, dump}, 2'b01);
        ddone = 1; cyc(); ddone = 0;
        chk("R8 dump ends", dump, 0);
        rx(4'h9);
        chk("R9 resp while idle", dump, 0);

        // Switch to master
        mode = 1; cyc();
        chk("R2 init on change", phy_init, 1);
        chk("R11 status held", mstat, 0);
        tick = 1; cyc(); tick = 0;
        chk("R2 tick during init", send, 0);
        idone = 1; cyc(); idone = 0;
        chk("R11 master status", mstat, 1);
        tick = 1; cyc(); tick = 0;
        chk("R3 sync on tick", {send, stype}, {1'b1, 4'h0});
        tick = 1; cyc(); tick = 0;
        chk("R6 busy tick", {send, stype}, {1'b1, 4'h0});
        sent = 1; cyc(); sent = 0;
        cyc();
        chk("R6 tick not queued", send, 0);
        btn = 1; cyc();
        chk("R4 press ignored", send, 0);
        btn = 0; cyc();
        chk("R4 release sync", {send, stype}, {1'b1, 4'h0});
        sent = 1; cyc(); sent = 0;
        rx(4'h1);
        chk("R5 response", {send, stype}, {1'b1, 4'h9});
        rx(4'h1);
        sent = 1; cyc(); sent = 0;
        chk("R5 gap after send", send, 0);
        cyc();
        chk("R5 pending answered", {send, stype}, {1'b1, 4'h9});
        sent = 1; cyc(); sent = 0;
        rx(4'h0);
        chk("R9 master ignores sync", send, 0);
        tick = 1; rxv = 1; rxt = 4'h1; cyc(); tick = 0; rxv = 0;
        chk("R5 request wins", {send, stype}, {1'b1, 4'h9});
        sent = 1; cyc(); sent = 0;
        cyc();
        chk("R6 coinciding tick dropped", send, 0);
        tick = 1; cyc(); tick = 0;
        mode = 0; cyc();
        chk("R2 cancel on change", {phy_init, send}, 2'b10);

        // Random slave
        idone = 1; cyc(); idone = 0;
        begin
            logic [1:0] st = 2'd0;
            for (int i = 0; i < 400; i++) begin
                logic [1:0] ns;
                rxv = ($urandom % 3) == 0; rxt = pick_type($urandom);
                sent = ($urandom % 3) == 0; ddone = ($urandom % 3) == 0;
                tick = $urandom % 2; btn = $urandom % 2;
                ns = slv_next(st, rxv && rxt == 4'h0, rxv && rxt == 4'h9, sent, ddone);
                cyc();
                chk("R7 R8 slave random", {dump, send, send ? stype : 4'h0},
                    {ns == 2'd3, ns == 2'd1, ns == 2'd1 ? 4'h1 : 4'h0});
                st = ns;
            end
        end
        rxv = 0; sent = 0; ddone = 0; tick = 0; btn = 0;
        mode = 1; cyc();
        idone = 1; cyc(); idone = 0;

        // Random master
        begin
            logic [1:0] st = 2'd0;
            logic       pd = 1'b0;
            logic       bp = 1'b0;
            for (int i = 0; i < 400; i++) begin
                logic [2:0] nx;
                rxv = ($urandom % 3) == 0; rxt = pick_type($urandom);
                sent = ($urandom % 3) == 0; ddone = $urandom % 2;
                tick = ($urandom % 6) == 0; btn = $urandom % 2;
                nx = mst_next(st, pd, tick || (bp && !btn), rxv && rxt == 4'h1, sent);
                cyc();
                chk("R5 R6 master random", {dump, send, send ? stype : 4'h0},
                    {1'b0, nx[2:1] != 2'd0, nx[2:1] == 2'd2 ? 4'h9 : 4'h0});
                st = nx[2:1]; pd = nx[0]; bp = btn;
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule